// File: doc/BRIEF.md
# Frame Length Limit Checker

This block decides whether a frame of a given length may pass, for either the transmit or the receive direction. It works out the largest allowed length from a few configuration bits and a programmable jumbo limit register. It then compares each offered frame length against that limit and returns a pass or drop verdict. A dropped frame also raises a one-cycle bus-error event, which the surrounding logic ORs into its interrupt status. The checker handles lengths only: buffer copying and descriptor handling belong to its neighbours.

Frame lengths arrive on a valid/ready stream, and verdicts leave on a second valid/ready stream. A frame is taken when `in_valid` and `in_ready` are both high on a clock edge. Its verdict appears in the next cycle and stays unchanged until `out_ready` accepts it. `in_ready` is high only when the verdict slot is empty or is being drained in the same cycle. An upstream source must therefore hold `in_valid`, `in_len` and `in_dir` steady until the transfer completes.

Configuration and the register write port are plain pins. The configuration is sampled at the same edge that takes the frame.

Top module: `frm_len_guard`

## Requirements
- R1: With jumbo mode off (cfg bit 3 clear), a transmit frame (`in_dir`=1) is dropped when its length exceeds 1518 bytes.
- R2: With jumbo mode off, the receive limit (`in_dir`=0) is 1538 bytes when cfg bit 8 is set and 1518 bytes otherwise. Cfg bit 8 has no effect on the transmit limit.
- R3: With cfg bit 3 set, the limit in both directions is the jumbo register value, clamped to the ceiling parameter `JUMBO_CEIL` (default 10240).
- R4: After reset, the jumbo register reads `JUMBO_CEIL`, `out_valid`, `err_evt` and `clamp_seen` are 0, and `in_ready` is 1.
- R5: A write on `lim_wr_en` stores `lim_wr_data` ANDed with a mask of the low `MASK_W` bits (default 14, mask 0x3FFF). The stored value is visible on `jumbo_lim` the cycle after the write.
- R6: `err_evt` pulses high for exactly the first cycle in which a drop verdict is presented. A pass verdict never raises it.
- R7: `clamp_seen` is set when a frame is taken in jumbo mode while the register exceeds `JUMBO_CEIL`. It then stays set until reset.
- R8: While `out_valid` is high and `out_ready` is low, the verdict holds stable and `in_ready` is low.
- R9: The comparison is strictly greater-than: a frame exactly at the limit passes (`out_drop`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bits | input | CFG_W (16) | Configuration bits; bit 3 enables jumbo mode, bit 8 selects the 1538-byte receive limit |
| lim_wr_en | input | 1 | Write strobe for the jumbo limit register |
| lim_wr_data | input | LEN_W (16) | Write data for the jumbo limit register |
| jumbo_lim | output | LEN_W (16) | Current jumbo limit register contents |
| in_valid | input | 1 | Frame length offered |
| in_ready | output | 1 | Checker can take a frame |
| in_len | input | LEN_W (16) | Frame length in bytes |
| in_dir | input | 1 | 1 = transmit, 0 = receive |
| out_valid | output | 1 | Verdict available |
| out_ready | input | 1 | Consumer takes the verdict |
| out_drop | output | 1 | 1 = frame exceeds its limit and is dropped |
| err_evt | output | 1 | One-cycle bus-error event for a dropped frame |
| clamp_seen | output | 1 | Sticky flag: the jumbo limit was clamped to the ceiling |

## Verification
The bench probes every limit at its edge, at the limit and one byte above it:
- 1518 for transmit.
- 1518 and 1538 for receive.
- The jumbo register value.
- The clamped ceiling.

An off-by-one comparator, or one that uses greater-or-equal, passes or drops the wrong frame at those edges. Other faults it targets:
- A design that applies the 1538 option to transmit would pass a 1519-byte transmit frame.
- A design that skips the clamp would pass a 10241-byte frame when the register holds 16383.
- A missing write mask would show up directly on `jumbo_lim`.

Back-pressure tests check that a stalled verdict neither changes nor repeats its error pulse. They also check that the `clamp_seen` flag survives a later, smaller register write.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
  localparam int unsigned STD_FRAME_MAX = 1518;
  localparam int unsigned EXT_FRAME_MAX = 1538;
endpackage

// File: rtl/flg_jumbo_reg.sv
module flg_jumbo_reg #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MASK_W    = 14,
  parameter int unsigned RESET_VAL = 10240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LEN_W-1:0] wr_data,
  output logic [LEN_W-1:0] q
);
  localparam logic [LEN_W-1:0] WR_MASK = LEN_W'((64'd1 << MASK_W) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= LEN_W'(RESET_VAL);
    else if (wr_en) q <= wr_data & WR_MASK;
  end
endmodule

// File: rtl/flg_limit_sel.sv
module flg_limit_sel
  import flg_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned JUMBO_CEIL = 10240
) (
  input  logic             jumbo_en,
  input  logic             ext_en,
  input  dir_e             dir,
  input  logic [LEN_W-1:0] reg_q,
  output logic [LEN_W-1:0] limit,
  output logic             clamped
);
  localparam logic [LEN_W-1:0] CEIL = LEN_W'(JUMBO_CEIL);
  localparam logic [LEN_W-1:0] STD  = LEN_W'(STD_FRAME_MAX);
  localparam logic [LEN_W-1:0] EXT  = LEN_W'(EXT_FRAME_MAX);

  logic over_ceil;
  assign over_ceil = reg_q > CEIL;

  always_comb begin
    clamped = 1'b0;
    if (jumbo_en) begin
      limit   = over_ceil ? CEIL : reg_q;
      clamped = over_ceil;
    end else if (dir == DIR_TX) begin
      limit = STD;
    end else begin
      limit = ext_en ? EXT : STD;
    end
  end
endmodule

// File: rtl/flg_verdict.sv
module flg_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic drop_in,
  input  logic out_ready,
  output logic out_valid,
  output logic out_drop,
  output logic err_evt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_drop  <= 1'b0;
      err_evt   <= 1'b0;
    end else begin
      err_evt <= take & drop_in;
      if (take) begin
        out_valid <= 1'b1;
        out_drop  <= drop_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frm_len_guard.sv
module frm_len_guard
  import flg_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned MASK_W     = 14,
  parameter int unsigned JUMBO_CEIL = 10240,
  parameter int unsigned JUMBO_BIT  = 3,
  parameter int unsigned EXT_BIT    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_bits,
  input  logic             lim_wr_en,
  input  logic [LEN_W-1:0] lim_wr_data,
  output logic [LEN_W-1:0] jumbo_lim,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_dir,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_drop,
  output logic             err_evt,
  output logic             clamp_seen
);
  logic [LEN_W-1:0] limit;
  logic             clamped;
  logic             take;

  flg_jumbo_reg #(.LEN_W(LEN_W), .MASK_W(MASK_W), .RESET_VAL(JUMBO_CEIL)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(lim_wr_en), .wr_data(lim_wr_data), .q(jumbo_lim)
  );

  flg_limit_sel #(.LEN_W(LEN_W), .JUMBO_CEIL(JUMBO_CEIL)) u_sel (
    .jumbo_en(cfg_bits[JUMBO_BIT]), .ext_en(cfg_bits[EXT_BIT]),
    .dir(dir_e'(in_dir)), .reg_q(jumbo_lim), .limit(limit), .clamped(clamped)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  flg_verdict u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .drop_in(in_len > limit),
    .out_ready(out_ready), .out_valid(out_valid), .out_drop(out_drop), .err_evt(err_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              clamp_seen <= 1'b0;
    else if (take && clamped) clamp_seen <= 1'b1;
  end
endmodule

// File: rtl/frm_len_guard_chk.sv
module frm_len_guard_chk #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned CFG_W     = 16,
  parameter int unsigned MASK_W    = 14,
  parameter int unsigned JUMBO_BIT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_bits,
  input logic             lim_wr_en,
  input logic [LEN_W-1:0] lim_wr_data,
  input logic [LEN_W-1:0] jumbo_lim,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LEN_W-1:0] in_len,
  input logic             in_dir,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_drop,
  input logic             err_evt,
  input logic             clamp_seen
);
  localparam logic [LEN_W-1:0] WMASK = LEN_W'((64'd1 << MASK_W) - 64'd1);

  p_tx_over_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_bits[JUMBO_BIT] && in_dir && in_len > LEN_W'(1518) |=> out_drop);
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr_en |=> jumbo_lim == ($past(lim_wr_data) & WMASK));
  p_err_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> out_valid && out_drop);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_seen |=> clamp_seen);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_drop) && !err_evt);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_bits[JUMBO_BIT] && in_len <= LEN_W'(1518) |=> !out_drop);
endmodule

bind frm_len_guard frm_len_guard_chk #(.LEN_W(LEN_W), .CFG_W(CFG_W), .MASK_W(MASK_W), .JUMBO_BIT(JUMBO_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
  .jumbo_lim(jumbo_lim), .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len), .in_dir(in_dir),
  .out_valid(out_valid), .out_ready(out_ready), .out_drop(out_drop), .err_evt(err_evt),
  .clamp_seen(clamp_seen)
);

// File: tb/frm_len_guard_bench.sv
`timescale 1ns/1ps
module frm_len_guard_bench;
  localparam int CEIL = 10240;
  logic clk = 0, rst_n = 0;
  logic [15:0] cfg_bits = '0, lim_wr_data = '0, in_len = '0;
  logic lim_wr_en = 0, in_valid = 0, in_dir = 0, out_ready = 1;
  logic [15:0] jumbo_lim;
  logic in_ready, out_valid, out_drop, err_evt, clamp_seen;
  int checks = 0, errors = 0;
  int mirror_reg = CEIL;
  bit exp_q[$];
  bit held = 0;

  always #2 clk = ~clk;

  frm_len_guard u_frm_len_guard (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_drop(int len, bit dir);
    int lim;
    if (cfg_bits[3]) lim = (mirror_reg > CEIL) ? CEIL : mirror_reg;
    else if (dir) lim = 1518;
    else lim = cfg_bits[8] ? 1538 : 1518;
    return len > lim;
  endfunction

  task automatic send(input int len, input bit dir);
    bit r;
    @(negedge clk);
    in_valid = 1; in_len = 16'(len); in_dir = dir;
    do begin
      #1 r = in_ready;
      @(posedge clk);
    end while (!r);
    exp_q.push_back(model_drop(len, dir));
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr_reg(input int v);
    @(negedge clk);
    lim_wr_en = 1; lim_wr_data = 16'(v);
    mirror_reg = v & 16'h3FFF;
    @(negedge clk);
    lim_wr_en = 0;
    chk("R5 jumbo_lim", jumbo_lim, mirror_reg);
  endtask

  // Monitor: compares verdicts and error pulses with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && exp_q.size() > 0) begin
        if (!held) chk("R6 err_evt on new verdict", err_evt, exp_q[0]);
        else       chk("R6 err_evt single pulse", err_evt, 0);
        chk("R1/R2/R3/R9 out_drop", out_drop, exp_q[0]);
        if (out_ready) void'(exp_q.pop_front());
      end else begin
        chk("R6 no err without verdict", err_evt, 0);
      end
      held = out_valid && !out_ready;
    end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 jumbo_lim reset", jumbo_lim, CEIL);
    chk("R4 out_valid reset", out_valid, 0);
    chk("R4 clamp reset", clamp_seen, 0);
    chk("R4 err reset", err_evt, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R4 in_ready reset", in_ready, 1);
    // R1 / R9 transmit standard limit
    send(1518, 1); send(1519, 1); send(64, 1);
    // R2 receive limits
    send(1518, 0); send(1519, 0);
    cfg_bits[8] = 1;
    send(1538, 0); send(1539, 0); send(1519, 1);
    // R3 jumbo with reset register
    cfg_bits[3] = 1;
    send(10240, 1); send(10241, 0);
    repeat (2) @(negedge clk);
    chk("R7 no clamp at ceiling", clamp_seen, 0);
    // R5 masked write
    wr_reg(16'h5FFF);
    send(8191, 0); send(8192, 1);
    wr_reg(16'hFFFF);
    send(10241, 1); send(10240, 0);
    repeat (2) @(negedge clk);
    chk("R7 clamp set", clamp_seen, 1);
    wr_reg(100);
    send(101, 0); send(100, 1);
    repeat (2) @(negedge clk);
    chk("R7 clamp sticky", clamp_seen, 1);
    // R8 back-pressure
    out_ready = 0;
    send(200, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R8 out_valid held", out_valid, 1);
      chk("R8 in_ready low", in_ready, 0);
      @(negedge clk);
    end
    out_ready = 1;
    repeat (3) @(negedge clk);
    chk("R8 drained", out_valid, 0);
    chk("scoreboard empty", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule